// File: doc/BRIEF.md
# Auto-Baud UART Field Receiver

This block receives byte-sized asynchronous serial fields on a single receive line whose bit rate is never configured. At the head of each transmission the controller sends a synchronization byte of 0x55. The receiver times that byte, derives the bit period in system clock cycles and locks. It then samples the fields that follow at that rate and presents each byte with a one-cycle valid strobe.

The line idles high, which is also its weak level, and is pulled low to signal a 0. A timer watches for a line that has not changed for too long. When the line sits still at either level beyond the limit, the receiver drops lock and treats the next falling edge as the start of a new synchronization byte. A measured period outside the supported rate span is refused. The receiver then stays unlocked and ignores the line until the idle timer expires. Limits are set through parameters: system clock frequency, slowest and fastest bit rate, and idle time in milliseconds.

Top module: `autobaud_rx`

## Requirements
- R1: After reset, `locked_o`, `valid_o` and `frame_err_o` are 0 and `period_o` is 0.
- R2: While unlocked and waiting, a falling edge starts a measurement over the byte 0x55, sent LSB first. The period is the cycle count from that edge to the fifth falling edge, divided by 8. When that period is in range, `period_o` takes it and `locked_o` rises.
- R3: Once locked, every field is received as follows. It has a start bit at 0, eight data bits with the least significant bit first, and a stop bit at 1. Each bit is sampled near its middle. The byte appears on `data_o` with `valid_o` high for exactly one cycle.
- R4: The accepted period range runs from CLK_HZ/BAUD_MAX (rounded down) to CLK_HZ/BAUD_MIN (rounded up), inclusive. A period outside this range leaves `locked_o` at 0, and the receiver then ignores all line activity until the idle timeout.
- R5: A start bit that reads 1 at its midpoint is treated as a glitch. No strobe and no error are produced, and the next falling edge starts a new field.
- R6: A stop bit sampled as 0 raises `frame_err_o` for exactly one cycle and produces no `valid_o`. `valid_o` and `frame_err_o` are never high together.
- R7: If the line stays at a constant level, high or low, for IDLE_MS milliseconds of clock cycles, `locked_o` falls. This applies in every state.
- R8: After a timeout, the next synchronization byte is measured afresh, and `period_o` follows the new rate.
- R9: `valid_o` is only asserted while `locked_o` is 1, and `period_o` does not change while lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a good byte on `data_o` |
| locked_o | output | 1 | High while a measured bit period is in use |
| frame_err_o | output | 1 | One-cycle strobe for a field whose stop bit read 0 |
| period_o | output | PW | Measured bit period in clock cycles; PW = $clog2(max period + 2) |

## Verification
Reception is swept over all 256 byte values at the fastest accepted period. This exposes any bit-order, bit-count or sampling-offset fault. Further bytes at slower periods show that sampling scales with the measured rate rather than with a fixed count. Synchronization bytes at periods just inside and just outside both range limits separate off-by-one errors in the range checks. Separate stimuli cover a short low glitch, a field with a low stop bit, and quiet lines held high and held low. Together these tell apart glitch rejection, framing detection and the two timeout cases.

// File: rtl/abr_pkg.sv
package abr_pkg;
    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_MEAS   = 3'd1,
        ST_REJECT = 3'd2,
        ST_IDLE   = 3'd3,
        ST_RECV   = 3'd4
    } abr_state_e;
endpackage

// File: rtl/abr_line_sync.sv
module abr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_i,
    output logic line_o,
    output logic fall_o,
    output logic change_o
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = rx_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], rx_i};
        end
    endgenerate

    always_comb prev_d = chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign line_o   = chain_q[STAGES-1];
    assign fall_o   = prev_q & ~chain_q[STAGES-1];
    assign change_o = prev_q ^ chain_q[STAGES-1];
endmodule

// File: rtl/abr_idle_timer.sv
module abr_idle_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic change_i,
    output logic expire_o
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (change_i)                  cnt_d = '0;
        else if (cnt_q == TW'(LIMIT))  cnt_d = cnt_q;
        else                           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expire_o = !change_i && (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/abr_rate_check.sv
module abr_rate_check #(
    parameter int unsigned MIN_P = 10,
    parameter int unsigned MAX_P = 500,
    parameter int          CW    = 12,
    parameter int          PW    = 9
) (
    input  logic [CW-1:0] span_i,
    output logic [PW-1:0] period_o,
    output logic          ok_o
);
    logic [CW-1:0] quot;

    always_comb begin
        quot     = span_i >> 3;
        period_o = quot[PW-1:0];
        ok_o     = (quot >= CW'(MIN_P)) && (quot <= CW'(MAX_P));
    end
endmodule

// File: rtl/autobaud_rx.sv
module autobaud_rx
    import abr_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned BAUD_MIN    = 2400,
    parameter int unsigned BAUD_MAX    = 115200,
    parameter int unsigned IDLE_MS     = 15,
    parameter int          SYNC_STAGES = 2,
    localparam int unsigned MIN_P      = CLK_HZ / BAUD_MAX,
    localparam int unsigned MAX_P      = (CLK_HZ + BAUD_MIN - 1) / BAUD_MIN,
    localparam int          PW         = $clog2(MAX_P + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_i,
    output logic [7:0]    data_o,
    output logic          valid_o,
    output logic          locked_o,
    output logic          frame_err_o,
    output logic [PW-1:0] period_o
);
    localparam int unsigned IDLE_CYC = (CLK_HZ / 1000) * IDLE_MS;
    localparam int unsigned SPAN_LIM = 8 * MAX_P + 7;
    localparam int          CW       = $clog2(8 * MAX_P + 9);

    typedef struct packed {
        abr_state_e    st;
        logic [CW-1:0] cnt;
        logic [2:0]    edges;
        logic [3:0]    bitn;
        logic [7:0]    shr;
        logic [PW-1:0] period;
        logic          locked;
        logic          valid;
        logic          ferr;
        logic [7:0]    data;
    } abr_regs_t;

    abr_regs_t state_d, state_q;

    logic          line, fall, change, expire, rate_ok;
    logic [PW-1:0] meas_period;
    logic [CW-1:0] span, target;

    abr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .rx_i(rx_i),
        .line_o(line), .fall_o(fall), .change_o(change)
    );

    abr_idle_timer #(.LIMIT(IDLE_CYC)) u_idle (
        .clk(clk), .rst(rst), .change_i(change), .expire_o(expire)
    );

    assign span = state_q.cnt + 1'b1;

    abr_rate_check #(.MIN_P(MIN_P), .MAX_P(MAX_P), .CW(CW), .PW(PW)) u_rate (
        .span_i(span), .period_o(meas_period), .ok_o(rate_ok)
    );

    // start bit is sampled after half a period, the rest one period apart
    assign target = (state_q.bitn == 4'd0) ? CW'(state_q.period >> 1)
                                           : CW'(state_q.period);

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        state_d.ferr  = 1'b0;
        unique case (state_q.st)
            ST_HUNT: begin
                if (fall) begin
                    state_d.st    = ST_MEAS;
                    state_d.cnt   = '0;
                    state_d.edges = '0;
                end
            end
            ST_MEAS: begin
                state_d.cnt = span;
                if (fall) begin
                    if (state_q.edges == 3'd3) begin
                        if (rate_ok) begin
                            state_d.period = meas_period;
                            state_d.locked = 1'b1;
                            state_d.st     = ST_IDLE;
                        end else begin
                            state_d.st     = ST_REJECT;
                        end
                    end else begin
                        state_d.edges = state_q.edges + 3'd1;
                    end
                end else if (state_q.cnt == CW'(SPAN_LIM)) begin
                    state_d.st = ST_REJECT;
                end
            end
            ST_REJECT: ;
            ST_IDLE: begin
                if (fall) begin
                    state_d.st   = ST_RECV;
                    state_d.cnt  = '0;
                    state_d.bitn = '0;
                end
            end
            ST_RECV: begin
                if (span >= target) begin
                    state_d.cnt = '0;
                    if (state_q.bitn == 4'd0) begin
                        if (line) state_d.st   = ST_IDLE;
                        else      state_d.bitn = 4'd1;
                    end else if (state_q.bitn == 4'd9) begin
                        state_d.st = ST_IDLE;
                        if (line) begin
                            state_d.valid = 1'b1;
                            state_d.data  = state_q.shr;
                        end else begin
                            state_d.ferr  = 1'b1;
                        end
                    end else begin
                        state_d.shr  = {line, state_q.shr[7:1]};
                        state_d.bitn = state_q.bitn + 4'd1;
                    end
                end else begin
                    state_d.cnt = span;
                end
            end
            default: state_d.st = ST_HUNT;
        endcase
        if (expire) begin
            state_d.st     = ST_HUNT;
            state_d.locked = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= '0;
            state_q.st <= ST_HUNT;
        end else begin
            state_q    <= state_d;
        end
    end

    assign data_o      = state_q.data;
    assign valid_o     = state_q.valid;
    assign locked_o    = state_q.locked;
    assign frame_err_o = state_q.ferr;
    assign period_o    = state_q.period;
endmodule

// File: rtl/abr_rx_chk.sv
module abr_rx_chk #(
    parameter int          PW    = 9,
    parameter int unsigned MIN_P = 10,
    parameter int unsigned MAX_P = 500
) (
    input logic          clk,
    input logic          rst,
    input logic          valid_i,
    input logic          ferr_i,
    input logic          locked_i,
    input logic [PW-1:0] period_i
);
    // R6
    valid_ferr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_i && ferr_i));

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> !valid_i);

    // R6
    ferr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ferr_i |=> !ferr_i);

    // R9
    valid_locked_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> locked_i);

    // R4
    period_range_chk: assert property (@(posedge clk) disable iff (rst)
        locked_i |-> (period_i >= PW'(MIN_P) && period_i <= PW'(MAX_P)));

    // R9
    period_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_i && $past(locked_i)) |-> $stable(period_i));
endmodule

bind autobaud_rx abr_rx_chk #(.PW(PW), .MIN_P(MIN_P), .MAX_P(MAX_P)) u_chk (
    .clk(clk), .rst(rst), .valid_i(valid_o), .ferr_i(frame_err_o),
    .locked_i(locked_o), .period_i(period_o)
);

// File: tb/autobaud_rx_test.sv
module autobaud_rx_test;
    localparam int unsigned TB_CLK  = 1_200_000;
    localparam int unsigned TB_IDLE = 5;
    localparam int          IDLE_CYC = (TB_CLK / 1000) * TB_IDLE;
    localparam int          TB_PW   = $clog2((TB_CLK + 2399) / 2400 + 2);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx  = 1'b1;
    logic [7:0]       data;
    logic             valid, locked, ferr;
    logic [TB_PW-1:0] period;

    int vcnt = 0, fcnt = 0, total = 0, fails = 0;
    logic [7:0] last = '0;
    bit done = 0;

    always #5 clk = ~clk;

    autobaud_rx #(.CLK_HZ(TB_CLK), .IDLE_MS(TB_IDLE)) uut (
        .clk(clk), .rst(rst), .rx_i(rx), .data_o(data), .valid_o(valid),
        .locked_o(locked), .frame_err_o(ferr), .period_o(period)
    );

    always @(negedge clk) begin
        if (!rst && valid) begin vcnt++; last = data; end
        if (!rst && ferr) fcnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int p, input logic stop);
        rx = 1'b0; hold(p);
        for (int i = 0; i < 8; i++) begin rx = b[i]; hold(p); end
        rx = stop; hold(p);
        rx = 1'b1;
    endtask

    task automatic good_byte(input logic [7:0] b, input int p, input string req);
        int v0 = vcnt;
        send(b, p, 1'b1);
        hold(p + 4);
        chk(vcnt == v0 + 1, req, "strobe count", vcnt - v0, 1);
        chk(last == b, req, "byte value", int'(last), int'(b));
    endtask

    task automatic sync(input int p);
        send(8'h55, p, 1'b1);
        hold(p + 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int v0, f0;
        hold(3);
        rst = 1'b0;
        hold(1);
        // R1 reset state
        chk(!locked && !valid && !ferr, "R1", "flags", {locked, valid, ferr}, 0);
        chk(period == 0, "R1", "period", int'(period), 0);

        // R2 lock at the fastest accepted period (R4 lower boundary)
        sync(10);
        chk(locked, "R2", "locked", locked, 1);
        chk(period == 10, "R2", "period", int'(period), 10);
        // R3 exhaustive byte sweep
        for (int b = 0; b < 256; b++) begin
            good_byte(b[7:0], 10, "R3");
            hold(3);
        end

        // R5 short low glitch
        v0 = vcnt; f0 = fcnt;
        rx = 1'b0; hold(2); rx = 1'b1; hold(30);
        chk(vcnt == v0 && fcnt == f0, "R5", "events after glitch",
            vcnt - v0 + fcnt - f0, 0);
        good_byte(8'hA5, 10, "R5");

        // R6 stop bit low
        v0 = vcnt; f0 = fcnt;
        send(8'h5A, 10, 1'b0);
        hold(4);
        chk(fcnt == f0 + 1, "R6", "error pulses", fcnt - f0, 1);
        chk(vcnt == v0, "R6", "strobes", vcnt - v0, 0);

        // R7 quiet high line
        hold(IDLE_CYC - 1000);
        chk(locked, "R7", "locked before limit", locked, 1);
        hold(2000);
        chk(!locked, "R7", "locked after limit", locked, 0);

        // R8 relock at a new rate
        sync(37);
        chk(locked && period == 37, "R8", "period", int'(period), 37);
        good_byte(8'h00, 37, "R8");
        good_byte(8'hFF, 37, "R8");
        good_byte(8'h3C, 37, "R8");

        // R7 line held low
        rx = 1'b0; hold(IDLE_CYC + 1000);
        chk(!locked, "R7", "locked after low hold", locked, 0);
        rx = 1'b1; hold(20);

        // R4 upper boundary accepted
        sync(500);
        chk(locked && period == 500, "R4", "period", int'(period), 500);
        good_byte(8'h96, 500, "R4");
        hold(IDLE_CYC + 100);
        chk(!locked, "R7", "locked after idle", locked, 0);

        // R4 too fast: rejected, following field ignored
        sync(9);
        chk(!locked, "R4", "locked at 9", locked, 0);
        v0 = vcnt; f0 = fcnt;
        send(8'h3C, 9, 1'b1); hold(20);
        chk(vcnt == v0 && fcnt == f0, "R4", "events while rejected",
            vcnt - v0 + fcnt - f0, 0);
        hold(IDLE_CYC + 100);

        // R4 too slow: rejected
        sync(501);
        chk(!locked, "R4", "locked at 501", locked, 0);
        hold(IDLE_CYC + 100);

        // R8 relock after rejection
        sync(10);
        chk(locked && period == 10, "R8", "period after reject", int'(period), 10);
        good_byte(8'hC3, 10, "R8");

        finish_run();
    end
endmodule